// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block is a direct-mapped data cache that sits between a processor load/store port and a next-level memory. The next-level memory moves one 32-bit word per handshake beat. With default parameters it holds 256 lines of four 32-bit words, which is 4 KB of data, on a 32-bit byte address. The cache uses a write-back policy with a dirty bit per line. A store that misses allocates the line.

The processor holds `cpu_req` and its address, direction, byte enables and write data until `cpu_ready` is high. A hit completes in the same cycle, with no memory traffic.

A miss first evicts the old line if it is dirty. It then refills the line starting with the requested word and wrapping around the block. A load is released in the beat that returns its word. The rest of the line keeps filling behind it, and any request presented meanwhile waits. A store miss waits for the complete block and then merges its bytes into the line.

Top module: `dm_cache`

## Requirements
- R1: Address fields are split as follows: the tag is bits 31..12, the line index is bits 11..4, and the word within the line is bits 3..2 (with parameters, the index is log2(LINES) bits above the word field and the tag is the remainder). Byte offset bits 1..0 do not affect lookup or data selection.
- R2: A request hits only when the indexed line is valid and its stored tag equals the address tag. A hit asserts `cpu_ready` in the cycle the request is presented, returns the addressed word for a load, and causes no memory traffic.
- R3: After reset every line is invalid: the first access to any address misses, and `cpu_ready` and `mem_req` are low while reset is held.
- R4: A store hit writes only the bytes whose `cpu_be` bit is set (bit n covers data bits 8n+7..8n), marks the line dirty, and causes no memory traffic.
- R5: A miss on a valid dirty line first issues four write beats carrying the old line, words 0 to 3 in order, at the old tag's addresses. No read beat comes before those four write beats. A miss on a clean or invalid line issues no write beat.
- R6: A refill issues exactly four read beats on the new line. They start at the requested word and advance by one word modulo the line size.
- R7: A load miss asserts `cpu_ready` in the same cycle as the acknowledgement of the first refill beat, with that beat's data on `cpu_rdata`.
- R8: A store miss asserts `cpu_ready` only after all four refill beats. Its enabled bytes are merged into the fetched word, and the line ends up dirty.
- R9: A request presented while a refill is still running is not answered until the last refill beat has completed, even when it targets the same line.
- R10: While `mem_req` is high and `mem_ack` is low, `mem_addr`, `mem_we` and (for writes) `mem_wdata` stay unchanged. Memory addresses are word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_be | input | 4 | Store byte enables |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | 32 | Load data, valid with `cpu_ready` |
| mem_req | output | 1 | Next-level beat request |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | ADDR_W | Word-aligned beat address |
| mem_wdata | output | 32 | Write beat data |
| mem_ack | input | 1 | Beat completes this cycle |
| mem_rdata | input | 32 | Read beat data, valid with `mem_ack` |

## Verification
The bench builds the cache with LINES=4 and WORDS=4 on a 32-bit address, and confines accesses to a 1 KB window. Many tags therefore compete for each of the four lines, so dirty evictions, clean evictions and refills that start at each of the four word offsets all occur often. The memory responder varies its latency from beat to beat. This exercises the hold rules on the memory port, and it opens the window in which a follow-on request must wait behind an early-released refill.

// File: rtl/dmc_pkg.sv
`timescale 1ns/1ps
package dmc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WBACK = 2'd1,
    ST_FILL  = 2'd2,
    ST_MERGE = 2'd3
  } dmc_state_e;
endpackage

// File: rtl/dmc_store.sv
`timescale 1ns/1ps
module dmc_store #(
  parameter int LINES  = 256,
  parameter int WORDS  = 4,
  parameter int TAG_W  = 20,
  localparam int IDX_W  = $clog2(LINES),
  localparam int WSEL_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic              rd_dirty,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [31:0]       rd_words [WORDS],
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_en,
  input  logic [WSEL_W-1:0] wr_sel,
  input  logic [3:0]        wr_be,
  input  logic [31:0]       wr_data,
  input  logic              inval_en,
  input  logic              inst_en,
  input  logic [TAG_W-1:0]  inst_tag,
  input  logic              dirty_set
);
  localparam int CELLS = LINES * WORDS;

  logic [31:0]      data_q [CELLS];
  logic [TAG_W-1:0] tag_q  [LINES];
  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;

  // data array: byte-lane write enables, no reset
  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int b = 0; b < 4; b++) begin
        if (wr_be[b]) data_q[{wr_idx, wr_sel}][8*b +: 8] <= wr_data[8*b +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (inst_en) tag_q[wr_idx] <= inst_tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      if (inval_en) valid_q[wr_idx] <= 1'b0;
      else if (inst_en) valid_q[wr_idx] <= 1'b1;
      if (inst_en) dirty_q[wr_idx] <= 1'b0;
      else if (dirty_set) dirty_q[wr_idx] <= 1'b1;
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];

  for (genvar w = 0; w < WORDS; w++) begin : g_rd
    assign rd_words[w] = data_q[{rd_idx, WSEL_W'(w)}];
  end
endmodule

// File: rtl/dmc_ctrl.sv
`timescale 1ns/1ps
module dmc_ctrl
  import dmc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINES  = 256,
  parameter int WORDS  = 4,
  localparam int IDX_W  = $clog2(LINES),
  localparam int WSEL_W = $clog2(WORDS),
  localparam int OFS_W  = 2,
  localparam int TAG_W  = ADDR_W - IDX_W - WSEL_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [3:0]        cpu_be,
  input  logic [31:0]       cpu_wdata,
  output logic              cpu_ready,
  output logic [31:0]       cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic              rd_valid,
  input  logic              rd_dirty,
  input  logic [TAG_W-1:0]  rd_tag,
  input  logic [31:0]       rd_words [WORDS],
  output logic [IDX_W-1:0]  wr_idx,
  output logic              wr_en,
  output logic [WSEL_W-1:0] wr_sel,
  output logic [3:0]        wr_be,
  output logic [31:0]       wr_data,
  output logic              inval_en,
  output logic              inst_en,
  output logic [TAG_W-1:0]  inst_tag,
  output logic              dirty_set
);
  dmc_state_e        st_q, st_d;
  logic [WSEL_W-1:0] beat_q, beat_d;
  logic              cap_en;

  logic [TAG_W-1:0]  tag_q;
  logic [IDX_W-1:0]  idx_q;
  logic [WSEL_W-1:0] word_q;
  logic              we_q;
  logic [3:0]        be_q;
  logic [31:0]       wdata_q;

  logic [TAG_W-1:0]  a_tag;
  logic [IDX_W-1:0]  a_idx;
  logic [WSEL_W-1:0] a_word;
  logic [WSEL_W-1:0] fill_sel;
  logic              hit, last_beat;
  logic              unused_ofs;

  assign a_tag      = cpu_addr[ADDR_W-1 -: TAG_W];
  assign a_idx      = cpu_addr[OFS_W+WSEL_W +: IDX_W];
  assign a_word     = cpu_addr[OFS_W +: WSEL_W];
  assign unused_ofs = ^cpu_addr[OFS_W-1:0];

  assign rd_idx    = (st_q == ST_IDLE) ? a_idx : idx_q;
  assign hit       = rd_valid && (rd_tag == a_tag);
  assign fill_sel  = word_q + beat_q;
  assign last_beat = (beat_q == WSEL_W'(WORDS - 1));
  assign inst_tag  = tag_q;

  always_comb begin
    st_d      = st_q;
    beat_d    = beat_q;
    cap_en    = 1'b0;
    cpu_ready = 1'b0;
    cpu_rdata = rd_words[a_word];
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = {tag_q, idx_q, fill_sel, {OFS_W{1'b0}}};
    mem_wdata = rd_words[beat_q];
    wr_idx    = idx_q;
    wr_en     = 1'b0;
    wr_sel    = fill_sel;
    wr_be     = 4'hF;
    wr_data   = mem_rdata;
    inval_en  = 1'b0;
    inst_en   = 1'b0;
    dirty_set = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        wr_idx = a_idx;
        if (cpu_req) begin
          if (hit) begin
            cpu_ready = 1'b1;
            if (cpu_we) begin
              wr_en     = 1'b1;
              wr_sel    = a_word;
              wr_be     = cpu_be;
              wr_data   = cpu_wdata;
              dirty_set = 1'b1;
            end
          end else begin
            cap_en   = 1'b1;
            inval_en = 1'b1;
            beat_d   = '0;
            st_d     = (rd_valid && rd_dirty) ? ST_WBACK : ST_FILL;
          end
        end
      end
      ST_WBACK: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = {rd_tag, idx_q, beat_q, {OFS_W{1'b0}}};
        if (mem_ack) begin
          beat_d = beat_q + WSEL_W'(1);
          if (last_beat) begin
            beat_d = '0;
            st_d   = ST_FILL;
          end
        end
      end
      ST_FILL: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          wr_en  = 1'b1;
          beat_d = beat_q + WSEL_W'(1);
          if ((beat_q == '0) && !we_q) begin
            cpu_ready = 1'b1;
            cpu_rdata = mem_rdata;
          end
          if (last_beat) begin
            inst_en = 1'b1;
            beat_d  = '0;
            st_d    = we_q ? ST_MERGE : ST_IDLE;
          end
        end
      end
      ST_MERGE: begin
        cpu_ready = 1'b1;
        wr_en     = 1'b1;
        wr_sel    = word_q;
        wr_be     = be_q;
        wr_data   = wdata_q;
        dirty_set = 1'b1;
        st_d      = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      beat_q <= '0;
    end else begin
      st_q   <= st_d;
      beat_q <= beat_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      tag_q   <= a_tag;
      idx_q   <= a_idx;
      word_q  <= a_word;
      we_q    <= cpu_we;
      be_q    <= cpu_be;
      wdata_q <= cpu_wdata;
    end
  end
endmodule

// File: rtl/dm_cache.sv
`timescale 1ns/1ps
module dm_cache #(
  parameter int ADDR_W = 32,
  parameter int LINES  = 256,
  parameter int WORDS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [3:0]        cpu_be,
  input  logic [31:0]       cpu_wdata,
  output logic              cpu_ready,
  output logic [31:0]       cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata
);
  localparam int IDX_W  = $clog2(LINES);
  localparam int WSEL_W = $clog2(WORDS);
  localparam int TAG_W  = ADDR_W - IDX_W - WSEL_W - 2;

  logic [IDX_W-1:0]  rd_idx, wr_idx;
  logic              rd_valid, rd_dirty;
  logic [TAG_W-1:0]  rd_tag, inst_tag;
  logic [31:0]       rd_words [WORDS];
  logic              wr_en, inval_en, inst_en, dirty_set;
  logic [WSEL_W-1:0] wr_sel;
  logic [3:0]        wr_be;
  logic [31:0]       wr_data;

  dmc_ctrl #(.ADDR_W(ADDR_W), .LINES(LINES), .WORDS(WORDS)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_be(cpu_be),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_tag(rd_tag),
    .rd_words(rd_words), .wr_idx(wr_idx), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_be(wr_be), .wr_data(wr_data), .inval_en(inval_en), .inst_en(inst_en),
    .inst_tag(inst_tag), .dirty_set(dirty_set)
  );

  dmc_store #(.LINES(LINES), .WORDS(WORDS), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_tag(rd_tag),
    .rd_words(rd_words), .wr_idx(wr_idx), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_be(wr_be), .wr_data(wr_data), .inval_en(inval_en), .inst_en(inst_en),
    .inst_tag(inst_tag), .dirty_set(dirty_set)
  );
endmodule

// File: rtl/dmc_chk.sv
`timescale 1ns/1ps
module dmc_chk #(
  parameter int ADDR_W = 32,
  parameter int WORDS  = 4,
  localparam int WSEL_W = $clog2(WORDS),
  localparam int WHI    = WSEL_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic              cpu_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic              mem_ack
);
  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!mem_req && !cpu_ready); // R3
    end
  end

  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                            && (!mem_we || $stable(mem_wdata))); // R10

  AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00); // R10

  AST_EVICT_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_ack |=> mem_req); // R5

  AST_NO_WRITE_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we |=> !(mem_req && mem_we)); // R5

  AST_FILL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we && mem_ack |=> !mem_req
      || (mem_addr[WHI:2] == WSEL_W'($past(mem_addr[WHI:2]) + 1'b1)
          && mem_addr[ADDR_W-1:WHI+1] == $past(mem_addr[ADDR_W-1:WHI+1]))); // R6

  AST_READY_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_req); // R2
endmodule

bind dm_cache dmc_chk #(.ADDR_W(ADDR_W), .WORDS(WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_ready(cpu_ready),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ack(mem_ack)
);

// File: tb/sim_dm_cache.sv
`timescale 1ns/1ps
module sim_dm_cache;
  localparam int LN = 4;
  localparam int WD = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_req, cpu_we;
  logic [31:0] cpu_addr, cpu_wdata;
  logic [3:0]  cpu_be;
  logic        cpu_ready;
  logic [31:0] cpu_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack;
  logic [31:0] mem_rdata;

  always #2 clk = ~clk;

  dm_cache #(.ADDR_W(32), .LINES(LN), .WORDS(WD)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_be(cpu_be), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input bit ok, input string rq, input logic [63:0] act,
                     input logic [63:0] exp, input string what);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // flat memory models: processor view and next-level contents
  logic [31:0] ref_mem [int];
  logic [31:0] nxt_mem [int];

  function automatic logic [31:0] pat(input int wa);
    return (wa * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction
  function automatic logic [31:0] ref_rd(input int wa);
    return ref_mem.exists(wa) ? ref_mem[wa] : pat(wa);
  endfunction
  function automatic logic [31:0] nxt_rd(input int wa);
    return nxt_mem.exists(wa) ? nxt_mem[wa] : pat(wa);
  endfunction

  // line occupancy model
  bit m_v     [LN];
  int m_blk   [LN];
  bit m_dirty [LN];

  // next-level responder
  bit          h_have, h_we, p_we;
  logic [31:0] h_addr, h_wd, p_wd;
  int          h_wait, lat_sel, p_wa;
  int          rd_n, wr_n;
  logic [32:0] beats [$];

  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
      if (p_we) begin nxt_mem[p_wa] = p_wd; wr_n++; end
      else rd_n++;
      beats.push_back({p_we, 32'(p_wa) << 2});
    end else if (rst_n && mem_req) begin
      if (!h_have) begin
        h_have = 1'b1; h_addr = mem_addr; h_we = mem_we; h_wd = mem_wdata;
        h_wait = lat_sel % 3; lat_sel++;
      end else begin
        chk(mem_addr == h_addr && mem_we == h_we && (!h_we || mem_wdata == h_wd),
            "R10", {32'h0, mem_addr}, {32'h0, h_addr}, "beat fields moved while waiting");
      end
      if (h_wait == 0) begin
        mem_ack = 1'b1; mem_rdata = nxt_rd(int'(h_addr >> 2));
        p_we = h_we; p_wa = int'(h_addr >> 2); p_wd = h_wd; h_have = 1'b0;
      end else h_wait--;
    end
  end

  task automatic access(input bit we, input int addr, input logic [3:0] be,
                        input logic [31:0] wd, input bit drain, input bit b2b);
    int wa, blk, idx, wrd, vblk, cyc, off, expn;
    bit ehit, ewb;
    logic [31:0] w;
    wa = addr >> 2; blk = wa / WD; idx = blk % LN; wrd = wa % WD;
    ehit = m_v[idx] && m_blk[idx] == blk;
    ewb  = !ehit && m_v[idx] && m_dirty[idx];
    vblk = m_blk[idx];
    cyc  = 0;
    @(negedge clk);
    if (!b2b) begin rd_n = 0; wr_n = 0; beats.delete(); end
    cpu_req = 1'b1; cpu_we = we; cpu_addr = 32'(addr); cpu_be = be; cpu_wdata = wd;
    forever begin
      #1;
      if (cpu_ready) break;
      @(negedge clk);
      cyc++;
      if (cyc > 2000) begin
        chk(1'b0, "R9", 64'(cyc), 64'd0, "request never completed");
        break;
      end
    end
    if (!b2b) chk((cyc == 0) == ehit, "R2", 64'(cyc), 64'(ehit ? 0 : 1), "hit latency");
    if (!we) chk(cpu_rdata == ref_rd(wa), "R7", {32'h0, cpu_rdata}, {32'h0, ref_rd(wa)}, "load data");
    if (!we && !ehit && !b2b)
      chk(mem_ack && rd_n == 0 && mem_addr == 32'(addr & ~3), "R7",
          {31'h0, mem_ack, mem_addr}, {32'h1, 32'(addr & ~3)}, "early release beat");
    if (we && !ehit) chk(rd_n == 4, "R8", 64'(rd_n), 64'd4, "store miss released before full block");
    if (b2b) chk(rd_n == 4, "R9", 64'(rd_n), 64'd4, "request answered during refill");
    if (we) begin
      w = ref_rd(wa);
      for (int b = 0; b < 4; b++) if (be[b]) w[8*b +: 8] = wd[8*b +: 8];
      ref_mem[wa] = w;
    end
    @(negedge clk);
    cpu_req = 1'b0;
    if (drain && !b2b) begin
      if (ehit) begin
        repeat (3) @(negedge clk);
        #1;
      end else begin
        for (int i = 0; i < 500 && rd_n < 4; i++) begin @(negedge clk); #1; end
      end
      expn = ehit ? 0 : (ewb ? 8 : 4);
      chk(beats.size() == expn, ehit ? "R4" : "R5", 64'(beats.size()), 64'(expn), "beat count");
      if (beats.size() == expn && !ehit) begin
        off = ewb ? 4 : 0;
        for (int k = 0; k < off; k++)
          chk(beats[k] == {1'b1, 32'((vblk * WD + k) * 4)}, "R5", 64'(beats[k]),
              {31'h0, 1'b1, 32'((vblk * WD + k) * 4)}, "writeback beat");
        for (int k = 0; k < 4; k++)
          chk(beats[off+k] == {1'b0, 32'((blk * WD + (wrd + k) % WD) * 4)}, "R6",
              64'(beats[off+k]), {32'h0, 32'((blk * WD + (wrd + k) % WD) * 4)}, "refill beat order");
        for (int k = 0; k < (ewb ? WD : 0); k++)
          chk(nxt_rd(vblk * WD + k) == ref_rd(vblk * WD + k), "R5",
              {32'h0, nxt_rd(vblk * WD + k)}, {32'h0, ref_rd(vblk * WD + k)}, "evicted word content");
      end
    end
    if (!ehit) begin m_v[idx] = 1'b1; m_blk[idx] = blk; m_dirty[idx] = we; end
    else m_dirty[idx] = m_dirty[idx] | we;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    chk(1'b0, "R9", 64'd0, 64'd1, "watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_be = '0;
    cpu_wdata = '0; mem_ack = 1'b0; mem_rdata = '0; h_have = 0; lat_sel = 0;
    p_we = 0; p_wa = 0; p_wd = '0; rd_n = 0; wr_n = 0;
    for (int i = 0; i < LN; i++) begin m_v[i] = 0; m_blk[i] = 0; m_dirty[i] = 0; end
    repeat (3) @(negedge clk);
    #1;
    chk(!cpu_ready && !mem_req, "R3", {62'h0, cpu_ready, mem_req}, 64'd0, "outputs in reset");
    @(negedge clk);
    rst_n = 1'b1;
    // R3: cold cache, address 0 must miss despite zero tag
    access(1'b0, 32'h00, 4'h0, 32'h0, 1'b1, 1'b0);
    access(1'b0, 32'h08, 4'h0, 32'h0, 1'b1, 1'b0);          // R2 hit
    access(1'b0, 32'h1C, 4'h0, 32'h0, 1'b1, 1'b0);          // R6 wrap from word 3
    access(1'b1, 32'h14, 4'b0101, 32'hA1B2C3D4, 1'b1, 1'b0); // R4 partial store hit
    access(1'b0, 32'h17, 4'h0, 32'h0, 1'b1, 1'b0);          // R1 byte offset ignored
    access(1'b0, 32'h5C, 4'h0, 32'h0, 1'b1, 1'b0);          // R1 same index, R5 dirty evict
    access(1'b0, 32'h14, 4'h0, 32'h0, 1'b1, 1'b0);          // R5 clean evict, merged data back
    access(1'b1, 32'h28, 4'hF, 32'h13572468, 1'b1, 1'b0);   // R8 store miss
    access(1'b0, 32'h28, 4'h0, 32'h0, 1'b1, 1'b0);
    access(1'b1, 32'h6B, 4'b1000, 32'hEE000000, 1'b1, 1'b0); // R8 with dirty victim
    access(1'b0, 32'h68, 4'h0, 32'h0, 1'b1, 1'b0);
    access(1'b0, 32'hC4, 4'h0, 32'h0, 1'b0, 1'b0);          // R7 early release
    access(1'b0, 32'hCC, 4'h0, 32'h0, 1'b0, 1'b1);          // R9 stalled behind refill
    for (int n = 0; n < 300; n++) begin
      logic [3:0] be;
      be = 4'($urandom_range(1, 15));
      access(1'($urandom_range(0, 1)), int'($urandom_range(0, 255)) * 4 + int'($urandom_range(0, 3)),
             be, $urandom, 1'b1, 1'b0);
    end
    finish_run();
  end
endmodule